// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a clocked register bank that captures a wide input word and presents it on a wider output bus. It has two operating modes. In the straight mode it behaves as a 25-bit register with one output per input bit. In the duplicating mode it registers 14 bits and drives each of them onto two outputs, so the two output banks are identical copies. It is meant to sit between a controller and a heavily loaded set of receivers, where the duplicating mode halves the load seen on each copy.

Two static configuration inputs select the behaviour. One picks straight or duplicating mode. The other picks which 14-bit slice of the input word is used in the duplicating mode: the low slice or the high slice. The configuration is registered together with the data, so a change shows at the outputs only after the next rising clock edge. Any output that the current mode does not use is driven low.

An active-low reset clears every register and forces all outputs low the moment it is asserted, without waiting for a clock edge. When reset is released, the outputs stay low until the first rising clock edge and follow the input from that edge onward. A single rising-edge clock stands in for a differential clock pair.

Top module: `cfg_fanout_reg`

## Requirements
- R1: While `rst_ni` is low, every bit of `q_o` is 0. Asserting it clears `q_o` at once, with no clock edge needed.
- R2: With `dup_mode_i` = 0, each rising edge of `clk_i` loads `q_o[24:0]` with the `d_i[24:0]` present at that edge.
- R3: With `dup_mode_i` = 0, the bits `q_o[27:25]` are 0 after every rising edge.
- R4: With `dup_mode_i` = 1 and `layout_b_i` = 0, a rising edge loads both `q_o[13:0]` and `q_o[27:14]` with `d_i[13:0]`.
- R5: With `dup_mode_i` = 1 and `layout_b_i` = 1, a rising edge loads both `q_o[13:0]` and `q_o[27:14]` with `d_i[24:11]`.
- R6: With `dup_mode_i` = 0, the value of `layout_b_i` has no effect on `q_o`.
- R7: A change on `dup_mode_i` or `layout_b_i` leaves `q_o` unchanged until the next rising edge, where the new mapping is applied.
- R8: After `rst_ni` rises, `q_o` stays 0 until the first rising edge of `clk_i`, which loads the mapped input.
- R9: Between rising edges, `q_o` holds its value whatever `d_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dup_mode_i | input | 1 | 0: straight 25-bit mode, 1: 14-bit duplicating mode |
| layout_b_i | input | 1 | Duplicating mode slice: 0 takes d_i[13:0], 1 takes d_i[24:11] |
| d_i | input | 25 | Input data word |
| q_o | output | 28 | Registered output; bank low [13:0], bank high [27:14] |

## Verification
The only state is the registered output word, so a wrong internal value shows at `q_o` on the edge that loads it and is replaced on the next edge. A wrong mapping shows as the two banks disagreeing in duplicating mode, as live bits in `q_o[27:25]` in straight mode, or as the wrong 14-bit slice. A reset path fault shows as non-zero outputs within the same low reset period, or as data loaded before the first clock edge after release. A configuration or data path that is not registered shows as `q_o` moving between edges.

// File: rtl/cfg_fanout_pkg.sv
package cfg_fanout_pkg;
  // Geometry of the block.
  localparam int unsigned IN_W   = 25;
  localparam int unsigned BANK_W = 14;

  // Operating mode as seen by the mapper.
  typedef enum logic {
    MODE_STRAIGHT = 1'b0,
    MODE_DUP      = 1'b1
  } fan_mode_e;

  // Slice choice used in the duplicating mode.
  typedef enum logic {
    SLICE_LOW  = 1'b0,
    SLICE_HIGH = 1'b1
  } fan_slice_e;
endpackage

// File: rtl/fanout_map.sv
module fanout_map
  import cfg_fanout_pkg::*;
#(
  parameter int unsigned IN_W_P   = IN_W,
  parameter int unsigned BANK_W_P = BANK_W
) (
  input  logic [IN_W_P-1:0]     d_i,
  input  fan_mode_e             mode_i,
  input  fan_slice_e            slice_i,
  output logic [2*BANK_W_P-1:0] word_o
);
  localparam int unsigned OUT_W = 2 * BANK_W_P;

  // Picks the 14-bit slice that feeds both banks.
  function automatic logic [BANK_W_P-1:0] pick_slice(
    input logic [IN_W_P-1:0] d,
    input fan_slice_e        s
  );
    return (s == SLICE_HIGH) ? d[IN_W_P-1 -: BANK_W_P] : d[BANK_W_P-1:0];
  endfunction

  // Builds the full output word for a given mode and slice.
  function automatic logic [OUT_W-1:0] map_word(
    input logic [IN_W_P-1:0] d,
    input fan_mode_e         m,
    input fan_slice_e        s
  );
    logic [OUT_W-1:0]    w;
    logic [BANK_W_P-1:0] sl;
    w = '0;
    if (m == MODE_STRAIGHT) begin
      w[IN_W_P-1:0] = d;
    end else begin
      sl = pick_slice(d, s);
      w  = {sl, sl};
    end
    return w;
  endfunction

  assign word_o = map_word(d_i, mode_i, slice_i);
endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= next_i;
  end
endmodule

// File: rtl/cfg_fanout_reg.sv
module cfg_fanout_reg
  import cfg_fanout_pkg::*;
#(
  parameter int unsigned IN_W_P   = IN_W,
  parameter int unsigned BANK_W_P = BANK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dup_mode_i,
  input  logic                  layout_b_i,
  input  logic [IN_W_P-1:0]     d_i,
  output logic [2*BANK_W_P-1:0] q_o
);
  localparam int unsigned OUT_W  = 2 * BANK_W_P;
  localparam int unsigned SLC_LO = IN_W_P - BANK_W_P;

  fan_mode_e          mode_w;
  fan_slice_e         slice_w;
  logic [OUT_W-1:0]   next_word_w;

  assign mode_w  = fan_mode_e'(dup_mode_i);
  assign slice_w = fan_slice_e'(layout_b_i);

  fanout_map #(
    .IN_W_P   (IN_W_P),
    .BANK_W_P (BANK_W_P)
  ) map_i (
    .d_i     (d_i),
    .mode_i  (mode_w),
    .slice_i (slice_w),
    .word_o  (next_word_w)
  );

  capture_bank #(
    .W (OUT_W)
  ) bank_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .next_i (next_word_w),
    .q_o    (q_o)
  );

  // Named views of the output banks for the checks below.
  logic [BANK_W_P-1:0] bank_lo_w;
  logic [BANK_W_P-1:0] bank_hi_w;
  assign bank_lo_w = q_o[BANK_W_P-1:0];
  assign bank_hi_w = q_o[OUT_W-1:BANK_W_P];

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0));

  assert_straight_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_mode_i |=> (q_o[IN_W_P-1:0] == $past(d_i)));

  assert_straight_spare_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_mode_i |=> (q_o[OUT_W-1:IN_W_P] == '0));

  assert_banks_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_mode_i |=> (bank_lo_w == bank_hi_w));

  assert_low_slice_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dup_mode_i && !layout_b_i) |=> (bank_lo_w == $past(d_i[BANK_W_P-1:0])));

  assert_high_slice_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dup_mode_i && layout_b_i) |=> (bank_lo_w == $past(d_i[IN_W_P-1:SLC_LO])));
endmodule

// File: tb/cfg_fanout_reg_tb.sv
module cfg_fanout_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic        dup;
    logic        lay;
    logic [24:0] d;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 25'h1FFFFFF},
    '{1'b0, 1'b1, 25'h0A5A5A5},
    '{1'b0, 1'b0, 25'h1000001},
    '{1'b1, 1'b0, 25'h0003FFF},
    '{1'b1, 1'b0, 25'h1FFC000},
    '{1'b1, 1'b0, 25'h0001234},
    '{1'b1, 1'b1, 25'h1FFC000},
    '{1'b1, 1'b1, 25'h0003FFF},
    '{1'b1, 1'b1, 25'h1555555},
    '{1'b0, 1'b1, 25'h0000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dup = 1'b0;
  logic        lay = 1'b0;
  logic [24:0] d = '0;
  logic [27:0] q;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_fanout_reg dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dup_mode_i (dup),
    .layout_b_i (lay),
    .d_i        (d),
    .q_o        (q)
  );

  // Model: each output bit looked up from its source input bit.
  function automatic logic [27:0] model(input logic m, input logic l, input logic [24:0] x);
    logic [27:0] e;
    for (int i = 0; i < 28; i++) begin
      if (!m) e[i] = (i < 25) ? x[i] : 1'b0;
      else    e[i] = l ? x[(i % 14) + 11] : x[i % 14];
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [27:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, q, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [27:0] held;
    // R1: reset state, with clock edges running and data present
    d = 25'h1ABCDEF;
    repeat (3) @(negedge clk);
    chk("R1 reset state", '0);

    // R8: release mid-cycle, outputs stay low until the first edge
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    #1;
    chk("R8 low before first edge", '0);
    @(negedge clk);
    chk("R8 first edge loads", model(1'b0, 1'b0, 25'h1ABCDEF));

    // Table walk: R2, R3, R4, R5
    for (int k = 0; k < NV; k++) begin
      dup = VECS[k].dup;
      lay = VECS[k].lay;
      d   = VECS[k].d;
      @(negedge clk);
      if (!VECS[k].dup)     chk("R2 R3 straight", model(1'b0, 1'b0, VECS[k].d));
      else if (!VECS[k].lay) chk("R4 low slice", model(1'b1, 1'b0, VECS[k].d));
      else                  chk("R5 high slice", model(1'b1, 1'b1, VECS[k].d));
    end

    // R3: straight mode with all inputs high, spare bits must be low
    dup = 1'b0; lay = 1'b0; d = '1;
    @(negedge clk);
    chk("R3 spare bits low", 28'h1FFFFFF);

    // R6: layout input toggled in straight mode changes nothing
    lay = 1'b1;
    @(negedge clk);
    chk("R6 layout ignored", 28'h1FFFFFF);

    // R9: data moves between edges, output holds
    d = 25'h0123456;
    held = q;
    #(CLK_PERIOD/4);
    chk("R9 hold between edges", held);
    @(negedge clk);
    chk("R9 next edge loads", model(1'b0, 1'b1, 25'h0123456));

    // R7: mode change waits for the edge
    dup = 1'b1; lay = 1'b0;
    held = q;
    #(CLK_PERIOD/4);
    chk("R7 mode change held", held);
    @(negedge clk);
    chk("R7 mode applied", model(1'b1, 1'b0, 25'h0123456));
    lay = 1'b1;
    #(CLK_PERIOD/4);
    chk("R7 layout change held", model(1'b1, 1'b0, 25'h0123456));
    @(negedge clk);
    chk("R7 layout applied", model(1'b1, 1'b1, 25'h0123456));

    // R1: asynchronous clear mid-cycle
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", '0);
    @(negedge clk);
    chk("R1 held low in reset", '0);

    // R8: second release in duplicating mode
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    #1;
    chk("R8 low after release", '0);
    @(negedge clk);
    chk("R8 loads after release", model(1'b1, 1'b1, 25'h0123456));

    finish_run();
  end
endmodule